// File: doc/BRIEF.md
# Interrupt Pin Sampler and Poll Arbiter

This block is the interrupt recognition front end of a small 8-bit processor core. It watches two active-low interrupt pins, one non-maskable and one maskable. The whole design runs on a single clock. The falling edge of the bus phase-2 clock is modelled as a one-cycle enable, `ph2_fall`, and the pins are sampled only in cycles where that enable is high. Both pins first pass through a two-stage synchroniser.

A high-to-low change seen between two consecutive non-maskable samples sets a sticky pending flag. One such sample is enough, and it may arrive on any cycle of an instruction. The flag is acted on only at the poll point, which is the phase-2 fall of the final cycle of an instruction, marked by `instr_end`. The maskable pin is a pure level sample taken at that same poll. At the poll, the block issues at most one one-cycle start request. The non-maskable request wins over the maskable one. The sequencer clears the pending flag with `seq_ack` once it has taken the non-maskable sequence.

Every pin on this block is a control strobe or level, so no valid/ready handshake is used and there is no back-pressure.

Top module: `intr_front_end`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `start_nmi` and `start_irq` are 0 and no non-maskable request is pending.
- R2: The pins are sampled only in cycles with `ph2_fall` = 1. A low pulse that begins after one sampling cycle and ends before the next is never seen, on either pin.
- R3: A non-maskable edge is a sample of `nmi_n` = 0 whose previous sample was 1. It sets the pending flag. A pin that stays low produces no further edge until it has been sampled high again.
- R4: A single low sample is enough to set the pending flag. The flag stays set after the pin returns high, and it keeps causing a non-maskable start at every poll until it is acknowledged.
- R5: A poll is a cycle with both `ph2_fall` = 1 and `instr_end` = 1. A start request is a one-cycle pulse in the cycle after a poll and never appears at any other time.
- R6: At a poll, the maskable request is the sampled level `irq_n` = 0 gated by `irq_disable` = 0. The non-maskable request ignores `irq_disable`. An edge sampled in the poll cycle itself counts toward that poll.
- R7: When both requests are present at a poll, only `start_nmi` is raised. The two start outputs are never high together.
- R8: `seq_ack` = 1 clears the pending flag on the next clock. A non-maskable edge sampled in the same cycle as the clear wins, and the flag stays set.
- R9: Each pin passes through two synchroniser stages. The first sample after reset only records the pin's level, so a pin held low through reset produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| irq_n | input | 1 | Maskable interrupt pin, active low, asynchronous |
| irq_disable | input | 1 | Interrupt-disable flag from the status register |
| ph2_fall | input | 1 | One-cycle enable marking the phase-2 falling edge |
| instr_end | input | 1 | High during the final cycle of an instruction |
| seq_ack | input | 1 | Sequencer has taken the non-maskable sequence; clears pending |
| start_nmi | output | 1 | One-cycle request to start the non-maskable sequence |
| start_irq | output | 1 | One-cycle request to start the maskable sequence |

## Verification
The assertions check the following on every cycle:
- the start outputs are mutually exclusive;
- a start pulse appears only in the cycle after a poll;
- `start_irq` never follows a poll with the disable flag set;
- a sampled edge always leaves the pending flag set, even when an acknowledge arrives in the same cycle;
- an acknowledge with no edge always clears the pending flag.

The bench scenarios cover what needs a history of pin levels:
- pulses that fall between sampling enables are invisible;
- a pin held low does not re-trigger;
- a pending request survives the end of its pulse;
- a pin held low through reset is ignored.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    POLL_NONE = 2'd0,
    POLL_NMI  = 2'd1,
    POLL_IRQ  = 2'd2
  } poll_pick_e;
endpackage

// File: rtl/intr_sync_chain.sv
module intr_sync_chain #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  // Stages reset to the inactive (high) level of the active-low pins.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q[s] <= '1;
        end else if (s == 0) begin
          stage_q[s] <= din;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[LAST];
endmodule

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic pin_sync_n,
  input  logic clr,
  output logic edge_now,
  output logic pend
);
  logic last_q;
  logic primed_q;

  // A low sample counts as an edge only when the previous sample was high,
  // and only once the first sample after reset has recorded the pin level.
  assign edge_now = smp_en && primed_q && last_q && !pin_sync_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q   <= 1'b1;
      primed_q <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (smp_en) begin
        last_q   <= pin_sync_n;
        primed_q <= 1'b1;
      end
      // A new edge has priority over the clear.
      pend <= edge_now | (pend & ~clr);
    end
  end
endmodule

// File: rtl/intr_poll_arb.sv
module intr_poll_arb
  import intr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic poll,
  input  logic nmi_hit,
  input  logic irq_sync_n,
  input  logic irq_disable,
  output logic start_nmi,
  output logic start_irq
);
  poll_pick_e pick;

  always_comb begin
    pick = POLL_NONE;
    if (poll) begin
      if (nmi_hit)                          pick = POLL_NMI;
      else if (!irq_sync_n && !irq_disable) pick = POLL_IRQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_nmi <= 1'b0;
      start_irq <= 1'b0;
    end else begin
      start_nmi <= (pick == POLL_NMI);
      start_irq <= (pick == POLL_IRQ);
    end
  end
endmodule

// File: rtl/intr_front_end.sv
module intr_front_end
  import intr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic irq_n,
  input  logic irq_disable,
  input  logic ph2_fall,
  input  logic instr_end,
  input  logic seq_ack,
  output logic start_nmi,
  output logic start_irq
);
  localparam int unsigned NPINS = 2;

  logic [NPINS-1:0] pins_sync;
  logic             nmi_edge;
  logic             nmi_pend;
  logic             poll;

  intr_sync_chain #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({irq_n, nmi_n}),
    .dout  (pins_sync)
  );

  intr_nmi_latch u_nmi (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (ph2_fall),
    .pin_sync_n (pins_sync[0]),
    .clr        (seq_ack),
    .edge_now   (nmi_edge),
    .pend       (nmi_pend)
  );

  assign poll = ph2_fall & instr_end;

  intr_poll_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll        (poll),
    .nmi_hit     (nmi_pend | nmi_edge),
    .irq_sync_n  (pins_sync[1]),
    .irq_disable (irq_disable),
    .start_nmi   (start_nmi),
    .start_irq   (start_irq)
  );
endmodule

// File: rtl/intr_front_end_chk.sv
module intr_front_end_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_disable,
  input logic ph2_fall,
  input logic instr_end,
  input logic seq_ack,
  input logic nmi_edge,
  input logic nmi_pend,
  input logic start_nmi,
  input logic start_irq
);
  assert_one_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_nmi && start_irq));

  assert_nmi_after_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph2_fall && instr_end) |=> !start_nmi);

  assert_irq_after_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph2_fall && instr_end) |=> !start_irq);

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2_fall && instr_end && irq_disable) |=> !start_irq);

  assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_edge |=> nmi_pend);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_ack && !nmi_edge) |=> !nmi_pend);

  assert_edge_needs_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_edge |-> ph2_fall);

  assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !seq_ack) |=> nmi_pend);
endmodule

bind intr_front_end intr_front_end_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_disable (irq_disable),
  .ph2_fall    (ph2_fall),
  .instr_end   (instr_end),
  .seq_ack     (seq_ack),
  .nmi_edge    (nmi_edge),
  .nmi_pend    (nmi_pend),
  .start_nmi   (start_nmi),
  .start_irq   (start_irq)
);

// File: tb/intr_front_end_bench.sv
module intr_front_end_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1, irq_n = 1'b1, irq_disable = 1'b0;
  logic ph2_fall = 1'b0, instr_end = 1'b0, seq_ack = 1'b0;
  logic start_nmi, start_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intr_front_end u_intr_front_end (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
    .irq_disable(irq_disable), .ph2_fall(ph2_fall), .instr_end(instr_end),
    .seq_ack(seq_ack), .start_nmi(start_nmi), .start_irq(start_irq)
  );

  // {nmi_n, irq_n, irq_disable, instr_end, seq_ack, exp_nmi, exp_irq}
  localparam logic [6:0] VEC [0:16] = '{
    7'b11_0_1_0_00, // prime sample, nothing pending
    7'b10_0_1_0_01, // R6 irq level taken
    7'b10_1_1_0_00, // R6 irq masked
    7'b10_0_0_0_00, // R5 no poll, no request
    7'b01_0_0_0_00, // R3 edge latched mid-instruction
    7'b11_0_1_0_10, // R4 pending acted on after pin released
    7'b11_0_1_0_10, // R4 still pending without ack
    7'b10_0_0_1_00, // R8 ack clears
    7'b10_0_1_0_01, // R8 cleared, irq now served
    7'b00_1_1_0_10, // R6/R7 edge at poll, ignores disable, wins
    7'b01_0_0_1_00, // R3 held low, no new edge; ack
    7'b01_0_1_0_00, // R3 held low does not re-trigger
    7'b11_0_0_0_00, // pin back high
    7'b01_0_0_1_00, // R8 edge in same cycle as ack
    7'b00_0_1_0_10, // R8/R7 edge survived; priority over irq
    7'b11_0_0_1_00, // ack
    7'b11_0_1_0_00  // idle poll
  };

  task automatic check(input string req, input logic en, input logic ei);
    n_chk++;
    if (start_nmi !== en || start_irq !== ei) begin
      n_bad++;
      $display("FAIL %s: start_nmi/start_irq = %b%b, expected %b%b",
               req, start_nmi, start_irq, en, ei);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One sampling cycle; outputs are checked one cycle later.
  task automatic sample(input logic ie, input logic ack,
                        input string req, input logic en, input logic ei);
    ph2_fall = 1'b1; instr_end = ie; seq_ack = ack;
    @(negedge clk);
    ph2_fall = 1'b0; instr_end = 1'b0; seq_ack = 1'b0;
    check(req, en, ei);
  endtask

  initial begin
    nmi_n = 1'b1;
    irq_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 1'b0);

    for (int v = 0; v < 17; v++) begin
      nmi_n = VEC[v][6]; irq_n = VEC[v][5]; irq_disable = VEC[v][4];
      idle(3);
      sample(VEC[v][3], VEC[v][2], $sformatf("R5 vector %0d", v),
             VEC[v][1], VEC[v][0]);
      idle(1);
      check("R5 pulse width", 1'b0, 1'b0);
    end

    // R2: pulses on both pins fully between two sampling cycles
    irq_disable = 1'b0;
    nmi_n = 1'b0; irq_n = 1'b0; idle(4);
    nmi_n = 1'b1; irq_n = 1'b1; idle(4);
    sample(1'b1, 1'b0, "R2 short pulses unseen", 1'b0, 1'b0);

    // R9: nmi held low through reset gives no request
    rst_n = 1'b0; nmi_n = 1'b0; idle(3);
    rst_n = 1'b1; idle(3);
    sample(1'b1, 1'b0, "R9 low at reset, first sample", 1'b0, 1'b0);
    idle(2);
    sample(1'b1, 1'b0, "R9 low at reset, second sample", 1'b0, 1'b0);
    nmi_n = 1'b1; idle(3);
    sample(1'b0, 1'b0, "R9 high sample", 1'b0, 1'b0);
    nmi_n = 1'b0; idle(3);
    sample(1'b1, 1'b0, "R3 edge after reset", 1'b1, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); end
    join_any
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule